// File: doc/BRIEF.md
# Instruction Address Breakpoint Comparator Unit

This block watches the instruction fetch address stream of a processor and flags a breakpoint when a fetch lands on one of a set of programmed half-word addresses. Software or a debug agent programs it through a small word-addressed register bank: one control word holding a global enable, followed by one word per comparator. Each comparator carries its own enable bit and a target address. The comparator count is a parameter.

Two comparator encodings are available, selected by a parameter. The legacy encoding reaches only the lowest 512 MB of the address space; it holds address bits [28:2] and a 2-bit half-word select field. The extended encoding holds address bits [31:1] and reaches any half-word in the 4 GB space. A hit is reported one clock after the fetch, naming the lowest-numbered matching comparator.

The fetch input is a one-way stream qualified by `fetch_valid`. The unit never applies back-pressure: it accepts and compares an address on every cycle in which `fetch_valid` is high. The hit output is also a one-way stream with no ready input. A consumer must take `hit_valid`/`hit_index` in the cycle they appear.

Top module: `fetch_bkpt_unit`

## Requirements
- R1: After reset the global enable and every comparator word read as 0, `hit_valid` is 0, and no fetch produces a hit.
- R2: A write to the control word (byte offset 0x0) takes effect only when write-data bit 1 is 1; bit 0 of such a write sets the global enable. A write with bit 1 at 0 leaves the enable unchanged.
- R3: Reading the control word returns the scheme in bits [31:28] (0 legacy, 1 extended), comparator count bits [6:4] in bits [14:12], count bits [3:0] in bits [7:4], the global enable in bit 0, and 0 elsewhere.
- R4: Comparator i is at byte offset 0x8 + 4*i. Writes to it need no key. A read returns the stored implemented bits: legacy stores [31:30], [28:2] and [0]; extended stores [31:1] and [0]; every other bit reads 0. Offset 0x4 and offsets past the last comparator read 0, and writes to them are ignored.
- R5: In the legacy scheme, a comparator matches only if fetch bits [31:29] are 0 and fetch bits [28:2] equal comparator bits [28:2].
- R6: In the legacy scheme, select field [31:30] chooses the matched half-word: 01 matches fetch bit 1 = 0, 10 matches fetch bit 1 = 1, 11 matches both, and 00 never matches. Fetch bit 0 is ignored.
- R7: In the extended scheme, a comparator matches when fetch bits [31:1] equal comparator bits [31:1]; fetch bit 0 is ignored.
- R8: A hit requires `fetch_valid`, the global enable and the comparator's bit-0 enable all to be 1.
- R9: `hit_valid` and `hit_index` are registered: they appear on the clock edge after the fetch is presented. When several comparators match, `hit_index` is the lowest index. `hit_index` is 0 when `hit_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | CFG_AW | Register byte offset (bits [1:0] ignored) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` (combinational) |
| fetch_valid | input | 1 | Fetch address qualifier |
| fetch_addr | input | 32 | Instruction fetch address |
| hit_valid | output | 1 | Breakpoint hit, one cycle after the fetch |
| hit_index | output | IDX_W | Lowest matching comparator index |

## Verification
The assertions assume that reset is held long enough for the first post-reset `$past` values to be the reset values. They also assume that `fetch_valid` is low while reset is active. The bench keeps both conditions: it holds `fetch_valid` at 0 throughout reset and until the first test task.

The bench changes register contents only through complete write cycles placed between fetches. As a result, a fetch is never compared against a comparator that changes in the same cycle. A legacy-scheme instance and an extended-scheme instance share every input. This lets one stimulus check both encodings against each other's expected miss.

// File: rtl/bpu_pkg.sv
package bpu_pkg;

  localparam int SCHEME_LEGACY = 0;
  localparam int SCHEME_EXT    = 1;

  localparam int CTRL_WORD     = 0;
  localparam int CMP_BASE_WORD = 2;
  localparam int KEY_BIT       = 1;
  localparam int EN_BIT        = 0;

  function automatic logic [31:0] impl_mask(input int scheme);
    return (scheme == SCHEME_LEGACY) ? 32'hDFFF_FFFD : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] ctrl_image(input int scheme, input int ncmp,
                                             input logic en);
    logic [6:0]  cnt;
    logic [31:0] img;
    cnt          = 7'(ncmp);
    img          = '0;
    img[31:28]   = 4'(scheme);
    img[14:12]   = cnt[6:4];
    img[7:4]     = cnt[3:0];
    img[EN_BIT]  = en;
    return img;
  endfunction

endpackage

// File: rtl/bpu_regs.sv
module bpu_regs
  import bpu_pkg::*;
#(
  parameter int NUM_CMP = 6,
  parameter int SCHEME  = SCHEME_LEGACY,
  parameter int CFG_AW  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_wr,
  input  logic [CFG_AW-1:0]        cfg_addr,
  input  logic [31:0]              cfg_wdata,
  output logic [31:0]              cfg_rdata,
  output logic                     glb_en,
  output logic [NUM_CMP-1:0][31:0] cmp_val
);

  localparam int WORD_W = CFG_AW - 2;
  localparam logic [31:0] MASK = impl_mask(SCHEME);

  logic [WORD_W-1:0] word_idx;
  logic [1:0]        unused_byte_sel;

  assign word_idx        = cfg_addr[CFG_AW-1:2];
  assign unused_byte_sel = cfg_addr[1:0];

  logic ctrl_sel;
  assign ctrl_sel = (word_idx == WORD_W'(CTRL_WORD));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_en <= 1'b0;
    end else if (cfg_wr && ctrl_sel && cfg_wdata[KEY_BIT]) begin
      glb_en <= cfg_wdata[EN_BIT];
    end
  end

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp_word
    logic sel;
    assign sel = (word_idx == WORD_W'(CMP_BASE_WORD + g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmp_val[g] <= '0;
      end else if (cfg_wr && sel) begin
        cmp_val[g] <= cfg_wdata & MASK;
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (ctrl_sel) begin
      cfg_rdata = ctrl_image(SCHEME, NUM_CMP, glb_en);
    end
    for (int i = 0; i < NUM_CMP; i++) begin
      if (word_idx == WORD_W'(CMP_BASE_WORD + i)) begin
        cfg_rdata = cmp_val[i];
      end
    end
  end

  // R2: an unkeyed control write leaves the global enable alone
  assert_unkeyed_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && ctrl_sel && !cfg_wdata[KEY_BIT]) |=> $stable(glb_en));

  // R4: bits outside the implemented mask never hold a 1
  assert_mask_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !ctrl_sel) |=> ((cmp_val[0] & ~MASK) == '0));

endmodule

// File: rtl/bpu_cmp.sv
module bpu_cmp
  import bpu_pkg::*;
#(
  parameter int SCHEME = SCHEME_LEGACY
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] cmp_val,
  input  logic [31:0] fetch_addr,
  output logic        match
);

  logic addr_eq;
  logic half_ok;

  if (SCHEME == SCHEME_LEGACY) begin : g_legacy
    logic [1:0] sel;
    logic [2:0] unused_bits;
    assign sel         = cmp_val[31:30];
    assign unused_bits = {cmp_val[29], cmp_val[1], fetch_addr[0]};
    assign addr_eq     = (fetch_addr[31:29] == 3'b000) &&
                         (fetch_addr[28:2] == cmp_val[28:2]);
    assign half_ok     = fetch_addr[1] ? sel[1] : sel[0];

    // R5: a legacy match never occurs outside the low code region
    assert_region_R5: assert property (@(posedge clk) disable iff (!rst_n)
      match |-> (fetch_addr[31:29] == 3'b000));

    // R6: select field 00 never produces a match
    assert_sel_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == 2'b00) |-> !match);
  end else begin : g_ext
    logic unused_bits;
    assign unused_bits = fetch_addr[0];
    assign addr_eq     = (fetch_addr[31:1] == cmp_val[31:1]);
    assign half_ok     = 1'b1;
  end

  assign match = cmp_val[EN_BIT] && addr_eq && half_ok;

  // R8: a disabled comparator never matches
  assert_cmp_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_val[EN_BIT] |-> !match);

endmodule

// File: rtl/bpu_hitsel.sv
module bpu_hitsel #(
  parameter int NUM_CMP = 6,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req,
  input  logic [NUM_CMP-1:0] match_vec,
  output logic               hit_valid,
  output logic [IDX_W-1:0]   hit_index
);

  logic [IDX_W-1:0] first_idx;
  logic             any_match;

  always_comb begin
    first_idx = '0;
    for (int i = NUM_CMP - 1; i >= 0; i--) begin
      if (match_vec[i]) first_idx = IDX_W'(i);
    end
  end

  assign any_match = |match_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_valid <= 1'b0;
      hit_index <= '0;
    end else begin
      hit_valid <= req && any_match;
      hit_index <= (req && any_match) ? first_idx : '0;
    end
  end

  // R9: a hit is always backed by a qualified match one cycle earlier
  assert_hit_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid |-> $past(req && any_match));

  // R9: the reported index names a real comparator
  assert_index_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid |-> (int'(hit_index) < NUM_CMP));

  // R9: index is zero while no hit is reported
  assert_idle_index_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_valid |-> (hit_index == '0));

endmodule

// File: rtl/fetch_bkpt_unit.sv
module fetch_bkpt_unit
  import bpu_pkg::*;
#(
  parameter int NUM_CMP = 6,
  parameter int SCHEME  = SCHEME_LEGACY,
  parameter int CFG_AW  = 8,
  localparam int IDX_W  = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              fetch_valid,
  input  logic [31:0]       fetch_addr,
  output logic              hit_valid,
  output logic [IDX_W-1:0]  hit_index
);

  logic                     glb_en;
  logic [NUM_CMP-1:0][31:0] cmp_val;
  logic [NUM_CMP-1:0]       match_vec;

  bpu_regs #(
    .NUM_CMP (NUM_CMP),
    .SCHEME  (SCHEME),
    .CFG_AW  (CFG_AW)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .glb_en    (glb_en),
    .cmp_val   (cmp_val)
  );

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    bpu_cmp #(
      .SCHEME (SCHEME)
    ) u_cmp (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmp_val    (cmp_val[g]),
      .fetch_addr (fetch_addr),
      .match      (match_vec[g])
    );
  end

  bpu_hitsel #(
    .NUM_CMP (NUM_CMP),
    .IDX_W   (IDX_W)
  ) u_hitsel (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (fetch_valid && glb_en),
    .match_vec (match_vec),
    .hit_valid (hit_valid),
    .hit_index (hit_index)
  );

  // R8: no hit unless the unit was globally enabled on the fetch cycle
  assert_global_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid |-> $past(glb_en));

  // R8: no hit without a valid fetch on the previous cycle
  assert_fetch_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(fetch_valid) |-> !hit_valid);

endmodule

// File: tb/tb_fetch_bkpt_unit.sv
`timescale 1ns/1ps
module tb_fetch_bkpt_unit;

  localparam int N = 6;
  localparam int AW = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic fetch_valid = 1'b0;
  logic [31:0] fetch_addr = '0;

  logic [31:0] rd_old, rd_new;
  logic hv_old, hv_new;
  logic [IW-1:0] hi_old, hi_new;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  fetch_bkpt_unit #(.NUM_CMP(N), .SCHEME(0), .CFG_AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(rd_old), .fetch_valid(fetch_valid),
    .fetch_addr(fetch_addr), .hit_valid(hv_old), .hit_index(hi_old));

  fetch_bkpt_unit #(.NUM_CMP(N), .SCHEME(1), .CFG_AW(AW)) dut_ext (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(rd_new), .fetch_valid(fetch_valid),
    .fetch_addr(fetch_addr), .hit_valid(hv_new), .hit_index(hi_new));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cw(input logic [AW-1:0] ofs, input logic [31:0] val);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = ofs; cfg_wdata = val;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] ofs);
    cfg_addr = ofs;
    #0.5;
  endtask

  task automatic fetch(input logic [31:0] a, input logic v);
    @(negedge clk);
    fetch_valid = v; fetch_addr = a;
    @(negedge clk);
    fetch_valid = 1'b0;
  endtask

  task automatic hit_is(input string tag, input logic [31:0] a,
                        input logic ov, input int oi, input logic nv, input int ni);
    fetch(a, 1'b1);
    chk({tag, " legacy valid"}, 32'(hv_old), 32'(ov));
    chk({tag, " ext valid"}, 32'(hv_new), 32'(nv));
    if (ov) chk({tag, " legacy index"}, 32'(hi_old), 32'(oi));
    if (nv) chk({tag, " ext index"}, 32'(hi_new), 32'(ni));
  endtask

  task automatic t_reset;
    rd(8'h00);
    chk("R1/R3 legacy ctrl after reset", rd_old, 32'h0000_0060);
    chk("R1/R3 ext ctrl after reset", rd_new, 32'h1000_0060);
    rd(8'h08);
    chk("R1 legacy comparator 0 cleared", rd_old, 32'h0);
    chk("R1 ext comparator 0 cleared", rd_new, 32'h0);
    chk("R1 hit_valid low", 32'({hv_old, hv_new}), 32'h0);
    hit_is("R1 fetch after reset", 32'h0, 1'b0, 0, 1'b0, 0);
  endtask

  task automatic t_ctrl_key;
    cw(8'h00, 32'h1); rd(8'h00);
    chk("R2 unkeyed enable ignored", rd_old, 32'h60);
    cw(8'h00, 32'h3); rd(8'h00);
    chk("R2/R3 keyed enable legacy", rd_old, 32'h61);
    chk("R2/R3 keyed enable ext", rd_new, 32'h1000_0061);
    cw(8'h00, 32'h2); rd(8'h00);
    chk("R2 keyed disable", rd_old, 32'h60);
    cw(8'h00, 32'hFFFF_FFFD); rd(8'h00);
    chk("R2 unkeyed all-ones ignored", rd_old, 32'h60);
    cw(8'h00, 32'h3);
  endtask

  task automatic t_cmp_rw;
    cw(8'h08, 32'hFFFF_FFFF); rd(8'h08);
    chk("R4 legacy stored bits", rd_old, 32'hDFFF_FFFD);
    chk("R4 ext stored bits", rd_new, 32'hFFFF_FFFF);
    cw(8'h04, 32'hFFFF_FFFF); rd(8'h04);
    chk("R4 reserved word legacy", rd_old, 32'h0);
    chk("R4 reserved word ext", rd_new, 32'h0);
    rd(8'h20);
    chk("R4 past last comparator", rd_old, 32'h0);
    cw(8'h1C, 32'h1234_5679); rd(8'h1C);
    chk("R4 last comparator offset", rd_old, 32'h1234_5679);
    cw(8'h1C, 32'h0); cw(8'h08, 32'h0); rd(8'h08);
    chk("R4 comparator rewrite", rd_new, 32'h0);
  endtask

  task automatic t_legacy;
    cw(8'h08, 32'h4000_1001);
    hit_is("R6 sel01 lower", 32'h1000, 1'b1, 0, 1'b0, 0);
    hit_is("R6 sel01 upper miss", 32'h1002, 1'b0, 0, 1'b0, 0);
    cw(8'h08, 32'h8000_1001);
    hit_is("R6 sel10 lower miss", 32'h1000, 1'b0, 0, 1'b0, 0);
    hit_is("R6 sel10 upper", 32'h1002, 1'b1, 0, 1'b0, 0);
    cw(8'h08, 32'hC000_1001);
    hit_is("R6 sel11 lower", 32'h1000, 1'b1, 0, 1'b0, 0);
    hit_is("R6 sel11 upper bit0 set", 32'h1003, 1'b1, 0, 1'b0, 0);
    hit_is("R5 next word miss", 32'h1004, 1'b0, 0, 1'b0, 0);
    hit_is("R5 top bits 001", 32'h2000_1000, 1'b0, 0, 1'b0, 0);
    hit_is("R5 top bits 111", 32'hE000_1000, 1'b0, 0, 1'b0, 0);
    cw(8'h08, 32'h0000_1001);
    hit_is("R6 sel00 never / R7 ext match", 32'h1000, 1'b0, 0, 1'b1, 0);
    cw(8'h08, 32'h0);
  endtask

  task automatic t_ext;
    cw(8'h0C, 32'hF000_0003);
    hit_is("R7 high address", 32'hF000_0002, 1'b0, 0, 1'b1, 1);
    hit_is("R7 bit0 ignored", 32'hF000_0003, 1'b0, 0, 1'b1, 1);
    hit_is("R7 other half-word", 32'hF000_0000, 1'b0, 0, 1'b0, 0);
    cw(8'h0C, 32'h0);
  endtask

  task automatic t_gating;
    cw(8'h08, 32'h4000_1001);
    cw(8'h00, 32'h2);
    hit_is("R8 global off legacy", 32'h1000, 1'b0, 0, 1'b0, 0);
    hit_is("R8 global off ext", 32'h4000_1000, 1'b0, 0, 1'b0, 0);
    cw(8'h00, 32'h3);
    hit_is("R8 global on", 32'h1000, 1'b1, 0, 1'b0, 0);
    fetch(32'h1000, 1'b0);
    chk("R8 fetch_valid low", 32'(hv_old), 32'h0);
    cw(8'h08, 32'h4000_1000);
    hit_is("R8 comparator off", 32'h1000, 1'b0, 0, 1'b0, 0);
  endtask

  task automatic t_priority;
    cw(8'h10, 32'h4000_3001);
    cw(8'h18, 32'h4000_3001);
    hit_is("R9 lowest legacy", 32'h3000, 1'b1, 2, 1'b0, 0);
    hit_is("R9 lowest ext", 32'h4000_3000, 1'b0, 0, 1'b1, 2);
    cw(8'h10, 32'h0);
    fetch(32'h0, 1'b0);
    @(negedge clk);
    fetch_valid = 1'b1; fetch_addr = 32'h3000;
    #1;
    chk("R9 no same-cycle hit", 32'(hv_old), 32'h0);
    @(negedge clk);
    fetch_valid = 1'b0;
    chk("R9 registered hit", 32'(hv_old), 32'h1);
    chk("R9 next index after disable", 32'(hi_old), 32'd4);
    @(negedge clk);
    chk("R9 hit drops", 32'(hv_old), 32'h0);
    chk("R9 index zero when idle", 32'(hi_old), 32'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl_key();
    t_cmp_rw();
    t_legacy();
    t_ext();
    t_gating();
    t_priority();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule